// File: doc/BRIEF.md
# Bunch-Crossing Identifier Synchronization Checker

This block checks, event by event, that the front-end electronics and the trigger/timing system agree on which bunch crossing an event belongs to. The timing side pushes one record (event number plus 12-bit crossing identifier) per accepted trigger into a 16-entry queue. The front-end side presents one block header per event, carrying the crossing identifier it latched. The block pairs the oldest queued record with the next header. It compares the two identifiers after adding a programmable offset to the timing-side value. It then emits one registered "process event" strobe with status flags.

The block never drops a timing-side event while the queue has room. When a front-end module goes silent, a programmable wait timer expires and the event is still released, marked as missing data. A lone identifier mismatch starts a one-event resynchronization check. A second consecutive mismatch latches a desynchronized state, which holds until software clears it. Saturating counters record mismatches, timeouts and successful resynchronizations.

Top module: `bcid_sync_chk`

## Requirements
- R1: After reset, evt_strobe, all event flags, q_overflow and all three counters are 0, and sync_state is LOCKED (encoding 0).
- R2: A record pushed with trig_valid becomes eligible the cycle after its push. Records are released strictly in push order, one evt_strobe per record, and evt_id carries the record's event number.
- R3: When fe_valid is high and a record is eligible, the record is released on the next clock edge. evt_mismatch is 1 exactly when fe_bcid differs from (record BCID + cfg_offset) modulo 4096.
- R4: From LOCKED (0), a mismatch moves sync_state to CHECK (1). From CHECK, a matching event returns it to LOCKED and increments cnt_resync.
- R5: A mismatch in CHECK moves sync_state to DESYNC (2). DESYNC persists through later events, matching or not, until clr_err is pulsed, which returns it to LOCKED. evt_desync is 1 for every event released while the state after that event is DESYNC.
- R6: A pending record with no front-end header is released after cfg_timeout consecutive waiting edges, with evt_missing=1 and evt_mismatch=0. sync_state is unchanged and cnt_timeout increments. The timer restarts from zero for the next record.
- R7: If fe_valid arrives on the very edge at which the timer would expire, the header wins: the event is compared normally, evt_missing=0 and cnt_timeout is unchanged.
- R8: fe_valid while the queue is empty has no effect: no strobe, no counter change, no state change.
- R9: cnt_mismatch counts every failed comparison in any state. All counters saturate at their maximum value (all ones) and never wrap.
- R10: A push into a full queue that is not relieved by a pop on the same edge is lost and sets the sticky q_overflow. clr_err clears q_overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Push a timing-side record |
| trig_evid | input | EVID_W | Event number of the pushed record |
| trig_bcid | input | BCID_W | Crossing identifier from the timing side |
| fe_valid | input | 1 | Front-end block header present |
| fe_bcid | input | BCID_W | Crossing identifier from the front-end header |
| cfg_offset | input | BCID_W | Offset added to the timing-side identifier before comparing |
| cfg_timeout | input | TMO_W | Waiting edges before a missing-data release (0 means maximum) |
| clr_err | input | 1 | Clear desynchronized state and overflow flag |
| evt_strobe | output | 1 | One-cycle process-event strobe |
| evt_id | output | EVID_W | Event number of the released event |
| evt_mismatch | output | 1 | Identifier comparison failed |
| evt_missing | output | 1 | Released by timeout without front-end data |
| evt_desync | output | 1 | Released while desynchronized |
| sync_state | output | 2 | 0 LOCKED, 1 CHECK, 2 DESYNC |
| q_overflow | output | 1 | Sticky: a record was lost to a full queue |
| cnt_mismatch | output | CNT_W | Saturating mismatch count |
| cnt_timeout | output | CNT_W | Saturating timeout count |
| cnt_resync | output | CNT_W | Saturating successful-resync count |

## Verification
The two functions that can land on the same edge are the timer expiry and the arrival of a late front-end header for the same record. The bench pushes one record with an 8-edge timeout and holds fe_valid back so that it is seen on exactly the eighth waiting edge. It then requires a normal compared release with no missing flag and an unchanged timeout count. A separate run without the header confirms that the expiry really falls on that edge. The run uses back-to-back records to show the timer restarts for the second record.

// File: rtl/bcid_sync_pkg.sv
package bcid_sync_pkg;

   typedef enum logic [1:0] {
      SYNC_LOCKED = 2'd0,
      SYNC_CHECK  = 2'd1,
      SYNC_DESYNC = 2'd2
   } sync_state_t;

   localparam int CNT_MM  = 0;
   localparam int CNT_TO  = 1;
   localparam int CNT_RS  = 2;
   localparam int NUM_CNT = 3;

endpackage

// File: rtl/bcid_evq.sv
module bcid_evq #(
   parameter int DW    = 36,
   parameter int DEPTH = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic          empty,
   output logic          ovf
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("bcid_evq: DEPTH must be a power of two >= 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [AW:0]   level;
   logic          full, do_push, do_pop;

   assign full    = (level == (AW+1)'(DEPTH));
   assign empty   = (level == '0);
   assign do_pop  = pop & ~empty;
   assign do_push = push & (~full | do_pop);
   assign ovf     = push & full & ~do_pop;
   assign rdata   = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/bcid_wait_timer.sv
module bcid_wait_timer #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pending,
   input  logic          fe_valid,
   input  logic [TW-1:0] limit,
   output logic          expire
);
   if (TW < 2) begin : g_bad_tw
      $error("bcid_wait_timer: TW must be at least 2");
   end

   logic [TW-1:0] waited;
   logic [TW-1:0] last;

   assign last   = limit - 1'b1;
   assign expire = pending & ~fe_valid & (waited == last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         waited <= '0;
      end else if (!pending || fe_valid || expire) begin
         waited <= '0;
      end else begin
         waited <= waited + 1'b1;
      end
   end
endmodule

// File: rtl/bcid_sync_fsm.sv
module bcid_sync_fsm
   import bcid_sync_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmp_valid,
   input  logic        cmp_match,
   input  logic        clr,
   output sync_state_t state,
   output sync_state_t state_nxt,
   output logic        inc_mm,
   output logic        inc_rs
);
   always_comb begin
      state_nxt = state;
      inc_mm    = cmp_valid & ~cmp_match;
      inc_rs    = 1'b0;
      if (cmp_valid) begin
         unique case (state)
            SYNC_LOCKED: if (!cmp_match) state_nxt = SYNC_CHECK;
            SYNC_CHECK: begin
               if (cmp_match) begin
                  state_nxt = SYNC_LOCKED;
                  inc_rs    = 1'b1;
               end else begin
                  state_nxt = SYNC_DESYNC;
               end
            end
            default: state_nxt = SYNC_DESYNC;
         endcase
      end
      if (clr) state_nxt = SYNC_LOCKED;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= SYNC_LOCKED;
      else        state <= state_nxt;
   end
endmodule

// File: rtl/bcid_sat_cnt.sv
module bcid_sat_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   if (W < 1) begin : g_bad_w
      $error("bcid_sat_cnt: W must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                 cnt <= '0;
      else if (inc && cnt != '1)  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/bcid_sync_chk.sv
module bcid_sync_chk
   import bcid_sync_pkg::*;
#(
   parameter int BCID_W = 12,
   parameter int EVID_W = 24,
   parameter int QDEPTH = 16,
   parameter int CNT_W  = 16,
   parameter int TMO_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_valid,
   input  logic [EVID_W-1:0] trig_evid,
   input  logic [BCID_W-1:0] trig_bcid,
   input  logic              fe_valid,
   input  logic [BCID_W-1:0] fe_bcid,
   input  logic [BCID_W-1:0] cfg_offset,
   input  logic [TMO_W-1:0]  cfg_timeout,
   input  logic              clr_err,
   output logic              evt_strobe,
   output logic [EVID_W-1:0] evt_id,
   output logic              evt_mismatch,
   output logic              evt_missing,
   output logic              evt_desync,
   output logic [1:0]        sync_state,
   output logic              q_overflow,
   output logic [CNT_W-1:0]  cnt_mismatch,
   output logic [CNT_W-1:0]  cnt_timeout,
   output logic [CNT_W-1:0]  cnt_resync
);
   localparam int RW = EVID_W + BCID_W;

   if (BCID_W < 1 || EVID_W < 1) begin : g_bad_w
      $error("bcid_sync_chk: identifier widths must be positive");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("bcid_sync_chk: CNT_W must be at least 2");
   end

   // record queue
   logic [RW-1:0]     q_head;
   logic              q_empty, q_ovf, pop;
   logic [EVID_W-1:0] head_id;
   logic [BCID_W-1:0] head_bcid, want_bcid;

   bcid_evq #(.DW(RW), .DEPTH(QDEPTH)) u_evq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (trig_valid),
      .wdata ({trig_evid, trig_bcid}),
      .pop   (pop),
      .rdata (q_head),
      .empty (q_empty),
      .ovf   (q_ovf)
   );

   assign {head_id, head_bcid} = q_head;
   assign want_bcid            = head_bcid + cfg_offset;

   // wait timer
   logic pending, expire, fe_hit, match;

   assign pending = ~q_empty;
   assign fe_hit  = fe_valid & pending;
   assign match   = (fe_bcid == want_bcid);
   assign pop     = fe_hit | expire;

   bcid_wait_timer #(.TW(TMO_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .pending  (pending),
      .fe_valid (fe_valid),
      .limit    (cfg_timeout),
      .expire   (expire)
   );

   // synchronization state
   sync_state_t st, st_nxt;
   logic        inc_mm, inc_rs;

   bcid_sync_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmp_valid (fe_hit),
      .cmp_match (match),
      .clr       (clr_err),
      .state     (st),
      .state_nxt (st_nxt),
      .inc_mm    (inc_mm),
      .inc_rs    (inc_rs)
   );

   assign sync_state = st;

   // error counters
   logic [NUM_CNT-1:0] inc_vec;
   logic [CNT_W-1:0]   cnt_arr [NUM_CNT];

   always_comb begin
      inc_vec         = '0;
      inc_vec[CNT_MM] = inc_mm;
      inc_vec[CNT_TO] = expire;
      inc_vec[CNT_RS] = inc_rs;
   end

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      bcid_sat_cnt #(.W(CNT_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (inc_vec[i]),
         .cnt   (cnt_arr[i])
      );
   end

   assign cnt_mismatch = cnt_arr[CNT_MM];
   assign cnt_timeout  = cnt_arr[CNT_TO];
   assign cnt_resync   = cnt_arr[CNT_RS];

   // event output register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evt_strobe   <= 1'b0;
         evt_id       <= '0;
         evt_mismatch <= 1'b0;
         evt_missing  <= 1'b0;
         evt_desync   <= 1'b0;
      end else begin
         evt_strobe <= pop;
         if (pop) begin
            evt_id       <= head_id;
            evt_mismatch <= fe_hit & ~match;
            evt_missing  <= ~fe_hit;
            evt_desync   <= (st_nxt == SYNC_DESYNC);
         end
      end
   end

   // sticky overflow
   always_ff @(posedge clk) begin
      if (!rst_n)       q_overflow <= 1'b0;
      else if (q_ovf)   q_overflow <= 1'b1;
      else if (clr_err) q_overflow <= 1'b0;
   end
endmodule

// File: rtl/bcid_sync_chk_sva.sv
module bcid_sync_chk_sva #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr_err,
   input logic             evt_strobe,
   input logic             evt_mismatch,
   input logic             evt_missing,
   input logic [1:0]       sync_state,
   input logic [CNT_W-1:0] cnt_mismatch,
   input logic [CNT_W-1:0] cnt_timeout,
   input logic [CNT_W-1:0] cnt_resync
);
   // R6
   missing_not_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_strobe && evt_missing) |-> !evt_mismatch);

   // R6
   missing_counted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_strobe && evt_missing) |-> (cnt_timeout != '0));

   // R5
   desync_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_state == 2'd2 && !clr_err) |=> (sync_state == 2'd2));

   // R4
   check_leaves_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_state == 2'd1 && !clr_err) |=> (sync_state == 2'd1 || evt_strobe));

   // R4
   state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_state != 2'd3);

   // R9
   mm_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((cnt_mismatch - $past(cnt_mismatch)) <= CNT_W'(1)));

   // R9
   mm_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_mismatch == '1) |=> (cnt_mismatch == '1));

   // R9
   rs_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_resync == '1) |=> (cnt_resync == '1));
endmodule

bind bcid_sync_chk bcid_sync_chk_sva #(.CNT_W(CNT_W)) u_sva (
   .clk          (clk),
   .rst_n        (rst_n),
   .clr_err      (clr_err),
   .evt_strobe   (evt_strobe),
   .evt_mismatch (evt_mismatch),
   .evt_missing  (evt_missing),
   .sync_state   (sync_state),
   .cnt_mismatch (cnt_mismatch),
   .cnt_timeout  (cnt_timeout),
   .cnt_resync   (cnt_resync)
);

// File: tb/bcid_sync_chk_bench.sv
module bcid_sync_chk_bench;
   localparam int BW = 12;
   localparam int EW = 24;
   localparam int CW = 4;
   localparam int TW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          trig_valid = 1'b0;
   logic [EW-1:0] trig_evid = '0;
   logic [BW-1:0] trig_bcid = '0;
   logic          fe_valid = 1'b0;
   logic [BW-1:0] fe_bcid = '0;
   logic [BW-1:0] cfg_offset = '0;
   logic [TW-1:0] cfg_timeout = 16'd1000;
   logic          clr_err = 1'b0;
   logic          evt_strobe, evt_mismatch, evt_missing, evt_desync, q_overflow;
   logic [EW-1:0] evt_id;
   logic [1:0]    sync_state;
   logic [CW-1:0] cnt_mismatch, cnt_timeout, cnt_resync;

   int total = 0;
   int bad   = 0;
   int exp_mm = 0, exp_to = 0, exp_rs = 0;

   logic          s_stb, s_mm, s_miss, s_ds;
   logic [EW-1:0] s_id;

   always #2 clk = ~clk;

   bcid_sync_chk #(.BCID_W(BW), .EVID_W(EW), .QDEPTH(16), .CNT_W(CW), .TMO_W(TW)) u_bcid_sync_chk (
      .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_evid(trig_evid),
      .trig_bcid(trig_bcid), .fe_valid(fe_valid), .fe_bcid(fe_bcid),
      .cfg_offset(cfg_offset), .cfg_timeout(cfg_timeout), .clr_err(clr_err),
      .evt_strobe(evt_strobe), .evt_id(evt_id), .evt_mismatch(evt_mismatch),
      .evt_missing(evt_missing), .evt_desync(evt_desync), .sync_state(sync_state),
      .q_overflow(q_overflow), .cnt_mismatch(cnt_mismatch), .cnt_timeout(cnt_timeout),
      .cnt_resync(cnt_resync)
   );

   function automatic int sat(input int v);
      return (v > (1 << CW) - 1) ? (1 << CW) - 1 : v;
   endfunction

   task automatic chk(input string what, input longint act, input longint exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic chk_counts(input string req);
      chk({req, " cnt_mismatch"}, cnt_mismatch, exp_mm);
      chk({req, " cnt_timeout"},  cnt_timeout,  exp_to);
      chk({req, " cnt_resync"},   cnt_resync,   exp_rs);
   endtask

   task automatic push(input int id, input int b);
      @(negedge clk);
      trig_valid = 1'b1; trig_evid = EW'(id); trig_bcid = BW'(b);
      @(negedge clk);
      trig_valid = 1'b0;
   endtask

   task automatic fe_send(input int b);
      @(negedge clk);
      fe_valid = 1'b1; fe_bcid = BW'(b);
      @(posedge clk); #1;
      s_stb = evt_strobe; s_id = evt_id; s_mm = evt_mismatch;
      s_miss = evt_missing; s_ds = evt_desync;
      @(negedge clk);
      fe_valid = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk); clr_err = 1'b1;
      @(negedge clk); clr_err = 1'b0;
   endtask

   task automatic wait_strobe(output int n);
      n = 0;
      for (int k = 0; k < 60; k++) begin
         @(posedge clk); #1;
         n++;
         if (evt_strobe) begin
            s_id = evt_id; s_miss = evt_missing; s_mm = evt_mismatch;
            break;
         end
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 strobe", evt_strobe, 0);
      chk("R1 flags", {evt_mismatch, evt_missing, evt_desync}, 0);
      chk("R1 state", sync_state, 0);
      chk("R1 overflow", q_overflow, 0);
      chk_counts("R1");
   endtask

   task automatic t_match();
      push(1, 100);
      fe_send(100);
      chk("R2 strobe", s_stb, 1);
      chk("R2 id", s_id, 1);
      chk("R3 match flag", s_mm, 0);
      chk("R3 state", sync_state, 0);
   endtask

   task automatic t_offset();
      cfg_offset = 12'd5;
      push(2, 4095);
      fe_send(4);
      chk("R3 offset wrap match", s_mm, 0);
      push(3, 10);
      fe_send(10);
      chk("R3 offset exposes mismatch", s_mm, 1);
      exp_mm++;
      chk("R4 to check", sync_state, 1);
      push(4, 20);
      fe_send(25);
      chk("R4 resync match", s_mm, 0);
      exp_rs++;
      chk("R4 back locked", sync_state, 0);
      cfg_offset = 12'd0;
      chk_counts("R4");
   endtask

   task automatic t_desync();
      push(20, 7);
      fe_send(8);
      exp_mm++;
      chk("R4 first mismatch", sync_state, 1);
      chk("R5 no desync yet", s_ds, 0);
      push(21, 9);
      fe_send(1);
      exp_mm++;
      chk("R5 second mismatch state", sync_state, 2);
      chk("R5 desync flag", s_ds, 1);
      push(22, 5);
      fe_send(5);
      chk("R5 match in desync still emitted", s_stb, 1);
      chk("R5 match keeps desync", sync_state, 2);
      chk("R5 desync flag on match", s_ds, 1);
      chk_counts("R9");
      pulse_clr();
      chk("R5 clear", sync_state, 0);
   endtask

   task automatic t_timeout();
      int n;
      cfg_timeout = 16'd8;
      @(negedge clk); trig_valid = 1'b1; trig_evid = 30; trig_bcid = 1;
      @(negedge clk); trig_evid = 31; trig_bcid = 2;
      @(negedge clk); trig_valid = 1'b0;
      wait_strobe(n);
      chk("R6 first expiry edge", n, 7);
      chk("R6 missing", s_miss, 1);
      chk("R6 id", s_id, 30);
      chk("R6 no mismatch", s_mm, 0);
      wait_strobe(n);
      chk("R6 timer restarts", n, 8);
      chk("R6 second id", s_id, 31);
      exp_to += 2;
      @(negedge clk);
      chk("R6 state unchanged", sync_state, 0);
      chk_counts("R6");
   endtask

   task automatic t_race();
      push(40, 3);
      repeat (6) @(negedge clk);
      chk("R7 nothing early", evt_strobe, 0);
      fe_send(3);
      chk("R7 strobe", s_stb, 1);
      chk("R7 not missing", s_miss, 0);
      chk("R7 id", s_id, 40);
      @(negedge clk);
      chk_counts("R7");
      cfg_timeout = 16'd1000;
   endtask

   task automatic t_ignore();
      fe_send(77);
      chk("R8 no strobe", s_stb, 0);
      repeat (2) @(negedge clk);
      chk("R8 state", sync_state, 0);
      chk_counts("R8");
   endtask

   task automatic t_overflow();
      int errs = 0;
      @(negedge clk);
      for (int i = 0; i < 17; i++) begin
         trig_valid = 1'b1; trig_evid = EW'(100 + i); trig_bcid = BW'(i * 3);
         @(negedge clk);
      end
      trig_valid = 1'b0;
      @(negedge clk);
      chk("R10 overflow set", q_overflow, 1);
      for (int i = 0; i < 16; i++) begin
         fe_send(i * 3);
         if (s_stb !== 1'b1 || s_id !== EW'(100 + i) || s_mm !== 1'b0) errs++;
      end
      chk("R2 order through full queue", errs, 0);
      fe_send(45);
      chk("R10 lost record not emitted", s_stb, 0);
      pulse_clr();
      chk("R10 overflow cleared", q_overflow, 0);
   endtask

   task automatic t_saturate();
      for (int i = 0; i < 14; i++) begin
         push(200 + i, 100);
         fe_send(101);
         exp_mm = sat(exp_mm + 1);
      end
      chk("R9 saturated mismatch", cnt_mismatch, exp_mm);
      chk("R9 at max", cnt_mismatch, (1 << CW) - 1);
      chk("R5 desync after run", sync_state, 2);
      pulse_clr();
      chk("R5 clear again", sync_state, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_match();
      t_offset();
      t_desync();
      t_timeout();
      t_race();
      t_ignore();
      t_overflow();
      t_saturate();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule